// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block derives three banks of divided clocks and one feedback clock from a single divider source. In normal mode that source is the block clock `clk` itself, so every `clk` cycle advances every divider by one step. In bypass mode the dividers step once per rising edge of an external reference instead. A select input picks that reference out of two, and it is synchronised into the `clk` domain. Bypass mode runs down to a reference that never toggles; the outputs then stay static.

Each bank's total ratio comes from two selects combined: a global prescale select and a per-bank select. The feedback ratio comes from the same prescale select and a 2-bit code. While the active-low master reset is low, the selects are captured, all dividers are cleared and every output-enable flag is low. Each output pin has an enable flag beside it, which stands in for a three-state driver. An active-low stop input holds the three bank outputs low and leaves the feedback output running. The stop engages and releases only while a bank output is low.

Top module: `clkdiv_bank_top`

## Requirements
- R1: Banks A and B (select bits `bank_sel[0]` and `bank_sel[1]`) divide by 4 (bit 0) or 8 (bit 1) with `pre_sel`=0, and by 8 (bit 0) or 16 (bit 1) with `pre_sel`=1.
- R2: Bank C (select bit `bank_sel[2]`) divides by 8 (bit 0) or 12 (bit 1) with `pre_sel`=0, and by 16 (bit 0) or 24 (bit 1) with `pre_sel`=1.
- R3: With `pre_sel`=0 the feedback output divides by 8, 16, 12 and 24 for `fb_sel` codes 00, 01, 10 and 11. With `pre_sel`=1 the same codes give 16, 32, 24 and 48.
- R4: Count divider steps from k=0, where step 0 is the first `clk` edge that samples `master_rst_n` high. At step k, an output of ratio N is high after that step exactly when (k mod N) < N/2. Every output therefore has a 50% duty cycle, and all rising edges line up at step 0.
- R5: With `pll_on`=0 the dividers step once per rising edge of `ref_a` (`ref_sel`=0) or `ref_b` (`ref_sel`=1). A reference held static gives no steps, so the outputs stay static.
- R6: While `master_rst_n` is sampled low, all clock outputs are 0 after that edge, all enable flags are 0 and the dividers restart. The enable flags are 1 after any edge that samples `master_rst_n` high. A bank or feedback clock output is never high while its enable flag is low.
- R7: While `stop_n` is low, the outputs of banks A, B and C are forced low. A bank's stop state changes only at a step after which that bank's undivided output is low. A high pulse is therefore never shortened, and a high pulse that follows a release is always full length.
- R8: The feedback output ignores `stop_n`.
- R9: `pre_sel`, `bank_sel` and `fb_sel` are captured only while `master_rst_n` is low. A change to them while running has no effect on any output until the next reset.
- R10: Banks A, B and C drive NA, NB and NC outputs respectively. All outputs of one bank carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and the divider source in normal mode |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| master_rst_n | input | 1 | Synchronous master reset and output enable, active low |
| stop_n | input | 1 | Bank clock stop, active low |
| pll_on | input | 1 | 1: divide `clk`; 0: divide the selected reference |
| ref_sel | input | 1 | Reference choice: 0 = `ref_a`, 1 = `ref_b` |
| ref_a | input | 1 | Reference 0, asynchronous |
| ref_b | input | 1 | Reference 1, asynchronous |
| pre_sel | input | 1 | Global prescale select |
| bank_sel | input | 3 | Per-bank ratio selects, bit 0 = A, bit 1 = B, bit 2 = C |
| fb_sel | input | 2 | Feedback ratio code |
| bank_a_clk | output | NA | Bank A clocks |
| bank_a_oe | output | 1 | Bank A output enable |
| bank_b_clk | output | NB | Bank B clocks |
| bank_b_oe | output | 1 | Bank B output enable |
| bank_c_clk | output | NC | Bank C clocks |
| bank_c_oe | output | 1 | Bank C output enable |
| fb_clk | output | 1 | Feedback clock |
| fb_oe | output | 1 | Feedback output enable |

## Verification
The bench builds the block with its default parameters: NA=5, NB=5, NC=4 and a two-stage reference synchroniser. The bank widths let every output bit be compared against the same expected level. A two-stage synchroniser keeps bypass latency at three `clk` cycles, so a reference with a six-cycle period still produces one clean step per edge. The default counter width reaches the largest ratio, 48, within a short run. This brings every prescale and feedback code, a stop window with its release, a stop held across reset release, and a select change while running into a few hundred cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Largest half period is 24 steps (ratio 48).
    localparam int HALF_W = 5;
    localparam int CNT_W  = HALF_W + 1;
    localparam int LANES  = 4;   // lanes 0..2 are banks A..C, lane 3 is feedback

    typedef logic [HALF_W-1:0] half_t;

    // Banks A/B: 2 or 4 steps per half period, doubled by the prescale.
    function automatic half_t half_ab(input logic pre, input logic sel);
        half_t base;
        base = sel ? half_t'(4) : half_t'(2);
        return pre ? half_t'(base << 1) : base;
    endfunction

    // Bank C: 4 or 6 steps per half period, doubled by the prescale.
    function automatic half_t half_c(input logic pre, input logic sel);
        half_t base;
        base = sel ? half_t'(6) : half_t'(4);
        return pre ? half_t'(base << 1) : base;
    endfunction

    // Feedback code order is behaviour: 00,01,10,11 -> 4,8,6,12 half steps.
    function automatic half_t half_fb(input logic pre, input logic [1:0] code);
        half_t base;
        case (code)
            2'b00:   base = half_t'(4);
            2'b01:   base = half_t'(8);
            2'b10:   base = half_t'(6);
            default: base = half_t'(12);
        endcase
        return pre ? half_t'(base << 1) : base;
    endfunction

endpackage

// File: rtl/clkdiv_src.sv
module clkdiv_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pll_on,
    input  logic ref_sel,
    input  logic ref_a,
    input  logic ref_b,
    output logic tick
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } src_st_t;

    src_st_t st_d, st_q;
    logic    ref_mux;

    assign ref_mux = ref_sel ? ref_b : ref_a;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[LAST-1:0], ref_mux};
        st_d.prev = st_q.sync[LAST];
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Normal mode steps every cycle; bypass steps on a synchronised rising edge.
    assign tick = pll_on | (st_q.sync[LAST] & ~st_q.prev);

endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane
    import clkdiv_pkg::*;
#(
    parameter bit GATED = 1'b1
) (
    input  logic  clk,
    input  logic  por_n,
    input  logic  run,
    input  logic  tick,
    input  half_t half,
    input  logic  stop_req,
    output logic  clk_out
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             raw;
        logic             gate;
    } lane_st_t;

    lane_st_t         st_d, st_q;
    logic [CNT_W-1:0] last_v;

    assign last_v = {half, 1'b0} - CNT_W'(1);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.raw = 1'b0;
        end else if (tick) begin
            st_d.raw = (st_q.cnt < {1'b0, half});
            st_d.cnt = (st_q.cnt == last_v) ? '0 : st_q.cnt + CNT_W'(1);
        end
        // Stop state may only move while the undivided output is low.
        if (!st_d.raw) st_d.gate = GATED ? stop_req : 1'b0;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (GATED) begin : g_gated
            assign clk_out = st_q.raw & ~st_q.gate;
        end else begin : g_free
            assign clk_out = st_q.raw;
        end
    endgenerate

endmodule

// File: rtl/clkdiv_bank_top.sv
module clkdiv_bank_top
    import clkdiv_pkg::*;
#(
    parameter int NA          = 5,
    parameter int NB          = 5,
    parameter int NC          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          master_rst_n,
    input  logic          stop_n,
    input  logic          pll_on,
    input  logic          ref_sel,
    input  logic          ref_a,
    input  logic          ref_b,
    input  logic          pre_sel,
    input  logic [2:0]    bank_sel,
    input  logic [1:0]    fb_sel,
    output logic [NA-1:0] bank_a_clk,
    output logic          bank_a_oe,
    output logic [NB-1:0] bank_b_clk,
    output logic          bank_b_oe,
    output logic [NC-1:0] bank_c_clk,
    output logic          bank_c_oe,
    output logic          fb_clk,
    output logic          fb_oe
);
    typedef struct packed {
        logic       pre;
        logic [2:0] bsel;
        logic [1:0] fsel;
        logic       oe;
    } cfg_st_t;

    cfg_st_t          cfg_d, cfg_q;
    logic             tick;
    half_t            half_v   [LANES];
    logic [LANES-1:0] lane_out;

    // Selects are captured only while the master reset is held.
    always_comb begin
        cfg_d    = cfg_q;
        cfg_d.oe = master_rst_n;
        if (!master_rst_n) begin
            cfg_d.pre  = pre_sel;
            cfg_d.bsel = bank_sel;
            cfg_d.fsel = fb_sel;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        half_v[0] = half_ab(cfg_q.pre, cfg_q.bsel[0]);
        half_v[1] = half_ab(cfg_q.pre, cfg_q.bsel[1]);
        half_v[2] = half_c (cfg_q.pre, cfg_q.bsel[2]);
        half_v[3] = half_fb(cfg_q.pre, cfg_q.fsel);
    end

    clkdiv_src #(.SYNC_STAGES(SYNC_STAGES)) src_i (
        .clk     (clk),
        .por_n   (por_n),
        .pll_on  (pll_on),
        .ref_sel (ref_sel),
        .ref_a   (ref_a),
        .ref_b   (ref_b),
        .tick    (tick)
    );

    genvar g;
    generate
        for (g = 0; g < LANES; g++) begin : g_lane
            clkdiv_lane #(.GATED(g < LANES - 1)) lane_i (
                .clk      (clk),
                .por_n    (por_n),
                .run      (master_rst_n),
                .tick     (tick),
                .half     (half_v[g]),
                .stop_req (~stop_n),
                .clk_out  (lane_out[g])
            );
        end
    endgenerate

    assign bank_a_clk = {NA{lane_out[0]}};
    assign bank_b_clk = {NB{lane_out[1]}};
    assign bank_c_clk = {NC{lane_out[2]}};
    assign fb_clk     = lane_out[3];
    assign bank_a_oe  = cfg_q.oe;
    assign bank_b_oe  = cfg_q.oe;
    assign bank_c_oe  = cfg_q.oe;
    assign fb_oe      = cfg_q.oe;

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
    parameter int NA = 5,
    parameter int NC = 4
) (
    input logic          clk,
    input logic          por_n,
    input logic          master_rst_n,
    input logic          stop_n,
    input logic [NA-1:0] bank_a_clk,
    input logic          bank_a_oe,
    input logic [NC-1:0] bank_c_clk,
    input logic          bank_c_oe,
    input logic          fb_clk,
    input logic          fb_oe
);
    logic primed_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) primed_q <= 1'b0;
        else        primed_q <= 1'b1;
    end

    p_quiet_in_reset_r6: assert property (@(posedge clk) disable iff (!por_n)
        !master_rst_n |=> (!bank_a_oe && !bank_c_oe && !fb_oe &&
                           bank_a_clk == '0 && bank_c_clk == '0 && !fb_clk));

    p_oe_on_release_r6: assert property (@(posedge clk) disable iff (!por_n)
        master_rst_n |=> (bank_a_oe && bank_c_oe && fb_oe));

    p_clk_needs_oe_r6: assert property (@(posedge clk) disable iff (!por_n)
        (bank_a_clk[0] |-> bank_a_oe) and (fb_clk |-> fb_oe));

    p_stop_holds_a_r7: assert property (@(posedge clk) disable iff (!por_n || !primed_q)
        (!stop_n && $past(!stop_n) && !bank_a_clk[0]) |=> !bank_a_clk[0]);

    p_stop_holds_c_r7: assert property (@(posedge clk) disable iff (!por_n || !primed_q)
        (!stop_n && $past(!stop_n) && !bank_c_clk[0]) |=> !bank_c_clk[0]);

endmodule

bind clkdiv_bank_top clkdiv_bank_chk #(.NA(NA), .NC(NC)) chk_i (
    .clk          (clk),
    .por_n        (por_n),
    .master_rst_n (master_rst_n),
    .stop_n       (stop_n),
    .bank_a_clk   (bank_a_clk),
    .bank_a_oe    (bank_a_oe),
    .bank_c_clk   (bank_c_clk),
    .bank_c_oe    (bank_c_oe),
    .fb_clk       (fb_clk),
    .fb_oe        (fb_oe)
);

// File: tb/clkdiv_bank_top_tb_top.sv
`timescale 1ns/1ps
module clkdiv_bank_top_tb_top;
    localparam int NA = 5;
    localparam int NB = 5;
    localparam int NC = 4;

    logic          clk = 1'b0;
    logic          por_n = 1'b0;
    logic          master_rst_n = 1'b0;
    logic          stop_n = 1'b1;
    logic          pll_on = 1'b1;
    logic          ref_sel = 1'b0;
    logic          ref_a = 1'b0;
    logic          ref_b = 1'b0;
    logic          pre_sel = 1'b0;
    logic [2:0]    bank_sel = '0;
    logic [1:0]    fb_sel = '0;
    logic [NA-1:0] bank_a_clk;
    logic          bank_a_oe;
    logic [NB-1:0] bank_b_clk;
    logic          bank_b_oe;
    logic [NC-1:0] bank_c_clk;
    logic          bank_c_oe;
    logic          fb_clk;
    logic          fb_oe;

    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        logic  a, b, c, fb, oe;
        string ctx;
    } item_t;

    item_t sb_q[$];

    always #4 clk = ~clk;

    clkdiv_bank_top #(.NA(NA), .NB(NB), .NC(NC), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .master_rst_n(master_rst_n), .stop_n(stop_n),
        .pll_on(pll_on), .ref_sel(ref_sel), .ref_a(ref_a), .ref_b(ref_b),
        .pre_sel(pre_sel), .bank_sel(bank_sel), .fb_sel(fb_sel),
        .bank_a_clk(bank_a_clk), .bank_a_oe(bank_a_oe),
        .bank_b_clk(bank_b_clk), .bank_b_oe(bank_b_oe),
        .bank_c_clk(bank_c_clk), .bank_c_oe(bank_c_oe),
        .fb_clk(fb_clk), .fb_oe(fb_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: pops one expected item per clock, sampled 2 ns after the edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                chk({it.ctx, " R1 R10 bank A"}, 32'(bank_a_clk), 32'({NA{it.a}}));
                chk({it.ctx, " R1 R10 bank B"}, 32'(bank_b_clk), 32'({NB{it.b}}));
                chk({it.ctx, " R2 R10 bank C"}, 32'(bank_c_clk), 32'({NC{it.c}}));
                chk({it.ctx, " R3 feedback"},   32'(fb_clk),     32'(it.fb));
                chk({it.ctx, " R6 enables"},
                    32'({bank_a_oe, bank_b_oe, bank_c_oe, fb_oe}), 32'({4{it.oe}}));
            end
        end
    end

    function automatic int ratio_ab(input logic pre, input logic sel);
        return pre ? (sel ? 16 : 8) : (sel ? 8 : 4);
    endfunction
    function automatic int ratio_c(input logic pre, input logic sel);
        return pre ? (sel ? 24 : 16) : (sel ? 12 : 8);
    endfunction
    function automatic int ratio_fb(input logic pre, input logic [1:0] code);
        int r;
        case (code)
            2'b00: r = 8;
            2'b01: r = 16;
            2'b10: r = 12;
            default: r = 24;
        endcase
        return pre ? 2 * r : r;
    endfunction

    task automatic push_idle(input string ctx);
        item_t it;
        it.a = 0; it.b = 0; it.c = 0; it.fb = 0; it.oe = 0; it.ctx = ctx;
        sb_q.push_back(it);
    endtask

    task automatic drain();
        while (sb_q.size() > 0) @(posedge clk);
        @(negedge clk);
    endtask

    // Driver: one divider step per clk cycle; stop_n low for steps st0 <= k < st1;
    // at step chg all select inputs are inverted while running (R9).
    task automatic run_case(input logic pre, input logic [2:0] bs, input logic [1:0] fs,
                            input int ncyc, input int st0, input int st1, input int chg,
                            input string ctx);
        int    ra, rb, rc, rf;
        logic  ga, gb, gc, s, wa, wb, wc;
        item_t it;
        ra = ratio_ab(pre, bs[0]);
        rb = ratio_ab(pre, bs[1]);
        rc = ratio_c(pre, bs[2]);
        rf = ratio_fb(pre, fs);
        s  = (st0 <= 0 && 0 < st1) ? 1'b0 : 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            master_rst_n = 1'b0;
            pll_on = 1'b1;
            pre_sel = pre; bank_sel = bs; fb_sel = fs;
            stop_n = s;
            push_idle("R6 reset");
        end
        ga = !s; gb = !s; gc = !s;
        for (int k = 0; k < ncyc; k++) begin
            @(negedge clk);
            s = (k >= st0 && k < st1) ? 1'b0 : 1'b1;
            stop_n = s;
            master_rst_n = 1'b1;
            if (k == chg) begin
                pre_sel = ~pre; bank_sel = ~bs; fb_sel = ~fs;
            end
            wa = (k % ra) < ra / 2;
            wb = (k % rb) < rb / 2;
            wc = (k % rc) < rc / 2;
            if (!wa) ga = !s;
            if (!wb) gb = !s;
            if (!wc) gc = !s;
            it.a  = wa & !ga;
            it.b  = wb & !gb;
            it.c  = wc & !gc;
            it.fb = (k % rf) < rf / 2;
            it.oe = 1'b1;
            it.ctx = ctx;
            sb_q.push_back(it);
        end
        @(negedge clk);
        master_rst_n = 1'b0;
        stop_n = 1'b1;
        push_idle("R6 re-reset");
        drain();
    endtask

    // Bypass: nref reference periods of 6 clk cycles on the chosen reference.
    task automatic run_bypass(input logic rs, input logic drive_a, input int nref,
                              output int rise_a, output int rise_fb);
        logic pa, pf;
        @(negedge clk);
        master_rst_n = 1'b0;
        pll_on = 1'b0; ref_sel = rs; ref_a = 1'b0; ref_b = 1'b0;
        pre_sel = 1'b0; bank_sel = 3'b000; fb_sel = 2'b00; stop_n = 1'b1;
        repeat (4) @(negedge clk);
        master_rst_n = 1'b1;
        rise_a = 0; rise_fb = 0; pa = 1'b0; pf = 1'b0;
        for (int p = 0; p < nref; p++) begin
            for (int c = 0; c < 6; c++) begin
                if (drive_a) ref_a = (c < 3); else ref_b = (c < 3);
                @(negedge clk);
                if (bank_a_clk[0] && !pa) rise_a++;
                if (fb_clk && !pf) rise_fb++;
                pa = bank_a_clk[0]; pf = fb_clk;
            end
        end
        ref_a = 1'b0; ref_b = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (bank_a_clk[0] && !pa) rise_a++;
            if (fb_clk && !pf) rise_fb++;
            pa = bank_a_clk[0]; pf = fb_clk;
        end
    endtask

    initial begin
        int ra, rf;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        chk("R6 reset state clocks", 32'({bank_a_clk, bank_b_clk, bank_c_clk, fb_clk}), 32'd0);
        chk("R6 reset state enables", 32'({bank_a_oe, bank_b_oe, bank_c_oe, fb_oe}), 32'd0);

        run_case(1'b0, 3'b010, 2'b00, 48, 0, 0, -1, "R4 pre0 code00");
        run_case(1'b1, 3'b101, 2'b11, 96, 0, 0, -1, "R4 pre1 code11");
        run_case(1'b0, 3'b111, 2'b10, 48, 5, 30, -1, "R7 R8 stop window");
        run_case(1'b1, 3'b000, 2'b01, 80, 0, 21, 10, "R7 R9 stop at release, select change");
        run_case(1'b0, 3'b000, 2'b01, 32, 0, 0, -1, "R9 selects relatched after reset");

        // R5: reference 1 toggling, 48 steps -> 12 rises on ratio 4, 6 on ratio 8.
        run_bypass(1'b1, 1'b0, 48, ra, rf);
        chk("R5 bypass ref_b bank A rises", 32'(ra), 32'd12);
        chk("R5 bypass ref_b feedback rises", 32'(rf), 32'd6);
        // R5: reference 0 selected and static while reference 1 toggles -> no steps.
        run_bypass(1'b0, 1'b0, 20, ra, rf);
        chk("R5 static reference bank A rises", 32'(ra), 32'd0);
        chk("R5 static reference feedback rises", 32'(rf), 32'd0);
        chk("R5 static reference enables", 32'({bank_a_oe, fb_oe}), 32'b11);
        // R5: reference 0 toggling with ref_sel=0.
        run_bypass(1'b0, 1'b1, 24, ra, rf);
        chk("R5 bypass ref_a bank A rises", 32'(ra), 32'd6);
        chk("R5 bypass ref_a feedback rises", 32'(rf), 32'd3);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule